// File: doc/BRIEF.md
# Sparse Token Readout with Neighbor Marking

This block keeps a per-channel record of which front-end channels saw a peak during an acquisition window and later hands those channels out one at a time when a readout token arrives. Empty channels are skipped, so the time a chip holds the token grows with its occupancy and not with its channel count. After the last recorded channel the token is passed on to the next chip in a daisy chain.

Optional neighbor marking also collects channels adjacent to a directly hit channel, so that charge shared below threshold is still read. Adjacency covers the channels on either side, the adjacent chip through two boundary lines (one at the lowest channel, one at the highest), and, when an option bit is set, an extra pairing between two chosen channels. A per-channel mask keeps a channel out of every marking path. The analog sample of each channel is not modelled; the channel index on the address output stands for it.

Operating mode comes from two control pins: acquisition enable high with configuration enable low records hits; both low is readout; configuration enable high clears all marks, which covers both the acquisition reset and the global reset.

Top module: `sparse_token_readout`

## Requirements
- R1: A channel's direct-hit mark is set only by a `peakHit` pulse sampled while `acqEnable`=1 and `cfgEnable`=0; `peakHit` pulses in readout mode change neither the marks nor `flagOut`.
- R2: A clock edge with `cfgEnable`=1 clears every mark, both latched boundary-line requests and `flagOut`.
- R3: `flagOut` goes high on the clock edge that samples the first unmasked peak and stays high until a clear.
- R4: In readout mode, the edge that samples `tokIn`=1 starts the visit: after that edge and each following edge, `addrOut` shows the next marked channel in ascending index order, one channel per clock, with `addrOe`=1; whenever `addrOe`=0, `addrOut` is all zeros.
- R5: `tokOut` rises on the edge after the last visited channel, or on the edge that samples `tokIn` when nothing is marked, stays high for 1.5 clock periods and is produced once per readout; a held `tokIn` starts no second pass.
- R6: With `neighEn`=1, the channels at index-1 and index+1 of a direct hit are marked too; marks made this way do not spread further. With `neighEn`=0 only direct hits are marked.
- R7: With `neighEn`=1, a pulse on `nbrLoIn` (`nbrHiIn`) during acquisition marks channel 0 (channel NUM_CH-1); in acquisition a direct hit on channel 0 (NUM_CH-1) drives `nbrLoOut` (`nbrHiOut`) high with `nbrLoOe` (`nbrHiOe`) high, and both enables are low otherwise.
- R8: With `neighEn`=1 and `bridgeEn`=1, channels LINK_A and LINK_B are neighbors of each other in addition to their index neighbors.
- R9: A channel whose `chanMask` bit is 1 is never marked, neither directly nor as a neighbor, and its hit neither sets `flagOut` nor marks its neighbors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout and capture clock |
| rstN | input | 1 | Asynchronous active-low reset |
| acqEnable | input | 1 | Acquisition enable (mode select) |
| cfgEnable | input | 1 | Configuration enable; high clears marks |
| peakHit | input | NUM_CH | Per-channel peak-found pulses |
| chanMask | input | NUM_CH | Per-channel mask, 1 = excluded |
| neighEn | input | 1 | Neighbor marking enable |
| bridgeEn | input | 1 | Extra adjacency between LINK_A and LINK_B |
| nbrLoIn | input | 1 | Neighbor request from the chip below channel 0 |
| nbrLoOut | output | 1 | Neighbor request toward the chip below |
| nbrLoOe | output | 1 | Drive enable for the low boundary line |
| nbrHiIn | input | 1 | Neighbor request from the chip above the top channel |
| nbrHiOut | output | 1 | Neighbor request toward the chip above |
| nbrHiOe | output | 1 | Drive enable for the high boundary line |
| tokIn | input | 1 | Readout token input |
| tokOut | output | 1 | Readout token output, 1.5 periods wide |
| addrOut | output | ADDR_W | Address of the visited channel |
| addrOe | output | 1 | Address drive enable, high while holding the token |
| flagOut | output | 1 | Event flag |

## Verification
The bench builds the block with NUM_CH=16 (a 4-bit address), LINK_A=3 and LINK_B=12. At that size every single-channel hit can be run with neighbor marking off and on, and every pair of distinct hit channels with neighbor marking on, a rotating masked channel, alternating bridge setting and boundary-line requests derived from the pair. The expected visit list is computed from the hit, mask and option values and compared address by address, followed by the token pulse width, the empty-chip pass-through and the refusal of a second pass.

// File: rtl/sparse_token_pkg.sv
package sparse_token_pkg;

  // Strobes from the control FSM to the mark datapath
  typedef struct packed {
    logic clearMarks;
    logic captureHits;
    logic loadPending;
    logic advance;
  } rdStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_PASS = 2'd2,
    ST_DONE = 2'd3
  } rdState_t;

endpackage

// File: rtl/str_mark_datapath.sv
module str_mark_datapath
  import sparse_token_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int ADDR_W = $clog2(NUM_CH),
  parameter int LINK_A = 7,
  parameter int LINK_B = 56
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobes_t        strobes,
  input  logic [NUM_CH-1:0] peakHit,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic              neighEn,
  input  logic              bridgeEn,
  input  logic              nbrLoIn,
  input  logic              nbrHiIn,
  output logic              markEmpty,
  output logic              pendingLast,
  output logic [ADDR_W-1:0] visitIdx,
  output logic              flagOut,
  output logic              ch0Hit,
  output logic              chTopHit
);

  localparam int TOP = NUM_CH - 1;
  localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

  logic [NUM_CH-1:0] hitReg;
  logic [NUM_CH-1:0] markVec;
  logic [NUM_CH-1:0] pending;
  logic [NUM_CH-1:0] lowOne;
  logic              extLoReg;
  logic              extHiReg;

  // Direct hits and boundary requests, captured only in acquisition
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitReg   <= '0;
      extLoReg <= 1'b0;
      extHiReg <= 1'b0;
    end else if (strobes.clearMarks) begin
      hitReg   <= '0;
      extLoReg <= 1'b0;
      extHiReg <= 1'b0;
    end else if (strobes.captureHits) begin
      hitReg   <= hitReg | (peakHit & ~chanMask);
      extLoReg <= extLoReg | nbrLoIn;
      extHiReg <= extHiReg | nbrHiIn;
    end
  end

  // Mark vector: direct hits plus one level of neighbors, masked
  for (genvar c = 0; c < NUM_CH; c++) begin : g_mark
    logic leftSrc;
    logic rightSrc;
    logic linkSrc;

    if (c == 0) begin : g_lo
      assign leftSrc = extLoReg;
    end else begin : g_lo
      assign leftSrc = hitReg[c-1];
    end

    if (c == TOP) begin : g_hi
      assign rightSrc = extHiReg;
    end else begin : g_hi
      assign rightSrc = hitReg[c+1];
    end

    if (c == LINK_A) begin : g_link
      assign linkSrc = bridgeEn & hitReg[LINK_B];
    end else if (c == LINK_B) begin : g_link
      assign linkSrc = bridgeEn & hitReg[LINK_A];
    end else begin : g_link
      assign linkSrc = 1'b0;
    end

    assign markVec[c] = ~chanMask[c] &
                        (hitReg[c] | (neighEn & (leftSrc | rightSrc | linkSrc)));
  end

  // Pending list walked by the token
  assign lowOne = pending & (~pending + ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
    end else if (strobes.loadPending) begin
      pending <= markVec;
    end else if (strobes.advance) begin
      pending <= pending & ~lowOne;
    end
  end

  always_comb begin
    visitIdx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (lowOne[i]) visitIdx = visitIdx | ADDR_W'(i);
    end
  end

  assign markEmpty   = (markVec == '0);
  assign pendingLast = (pending != '0) && ((pending & (pending - ONE)) == '0);
  assign flagOut     = |hitReg;
  assign ch0Hit      = hitReg[0];
  assign chTopHit    = hitReg[TOP];

  // R2: a clear leaves no hit and no flag behind
  a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearMarks |=> (hitReg == '0) && !flagOut);

  // R3: the flag holds until a clear
  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flagOut && !strobes.clearMarks) |=> flagOut);

  // R4: each step retires exactly one pending channel
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && pending != '0 && !strobes.loadPending)
      |=> $countones(pending) == $countones($past(pending)) - 1);

  // R9: a masked channel never enters the pending list
  a_r9_masked_pending: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadPending |=> (pending & $past(chanMask)) == '0);

endmodule

// File: rtl/str_token_ctrl.sv
module str_token_ctrl
  import sparse_token_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       acqEnable,
  input  logic       cfgEnable,
  input  logic       tokIn,
  input  logic       markEmpty,
  input  logic       pendingLast,
  output rdStrobes_t strobes,
  output logic       acqMode,
  output logic       addrOe,
  output logic       tokOut
);

  rdState_t state;
  rdState_t stateNext;
  logic     rdMode;
  logic     tokRise;
  logic     tokTail;

  assign acqMode = acqEnable & ~cfgEnable;
  assign rdMode  = ~acqEnable & ~cfgEnable;

  always_comb begin
    stateNext           = state;
    strobes.clearMarks  = cfgEnable;
    strobes.captureHits = acqMode;
    strobes.loadPending = 1'b0;
    strobes.advance     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (rdMode && tokIn) begin
          strobes.loadPending = 1'b1;
          stateNext = markEmpty ? ST_PASS : ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (!rdMode) begin
          stateNext = ST_IDLE;
        end else begin
          strobes.advance = 1'b1;
          if (pendingLast) stateNext = ST_PASS;
        end
      end
      ST_PASS: stateNext = rdMode ? ST_DONE : ST_IDLE;
      ST_DONE: if (!rdMode) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // Token out: one full period from the rising edge plus half a period
  // extended by a falling-edge copy
  assign tokRise = (state == ST_PASS);

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) tokTail <= 1'b0;
    else       tokTail <= tokRise;
  end

  assign tokOut = tokRise | tokTail;
  assign addrOe = (state == ST_SCAN);

  // R5: the token leaves on the edge after the last visited channel
  a_r5_token_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN && rdMode && pendingLast) |=> tokRise);

  // R5: an empty chip passes the token on the sampling edge
  a_r5_empty_pass: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && rdMode && tokIn && markEmpty) |=> tokRise && !addrOe);

  // R4: a loaded non-empty list drives the address bus next cycle
  a_r4_load_drives: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && rdMode && tokIn && !markEmpty) |=> addrOe);

  // R5: a token pulse is not followed by a second one in the same readout
  a_r5_single_pass: assert property (@(posedge clk) disable iff (!rstN)
    (tokRise && rdMode) |=> !tokRise);

endmodule

// File: rtl/sparse_token_readout.sv
module sparse_token_readout
  import sparse_token_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int ADDR_W = $clog2(NUM_CH),
  parameter int LINK_A = 7,
  parameter int LINK_B = 56
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              acqEnable,
  input  logic              cfgEnable,
  input  logic [NUM_CH-1:0] peakHit,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic              neighEn,
  input  logic              bridgeEn,
  input  logic              nbrLoIn,
  output logic              nbrLoOut,
  output logic              nbrLoOe,
  input  logic              nbrHiIn,
  output logic              nbrHiOut,
  output logic              nbrHiOe,
  input  logic              tokIn,
  output logic              tokOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic              flagOut
);

  rdStrobes_t        strobes;
  logic              markEmpty;
  logic              pendingLast;
  logic [ADDR_W-1:0] visitIdx;
  logic              acqMode;
  logic              ch0Hit;
  logic              chTopHit;

  str_token_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .acqEnable  (acqEnable),
    .cfgEnable  (cfgEnable),
    .tokIn      (tokIn),
    .markEmpty  (markEmpty),
    .pendingLast(pendingLast),
    .strobes    (strobes),
    .acqMode    (acqMode),
    .addrOe     (addrOe),
    .tokOut     (tokOut)
  );

  str_mark_datapath #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W),
    .LINK_A(LINK_A),
    .LINK_B(LINK_B)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .peakHit    (peakHit),
    .chanMask   (chanMask),
    .neighEn    (neighEn),
    .bridgeEn   (bridgeEn),
    .nbrLoIn    (nbrLoIn),
    .nbrHiIn    (nbrHiIn),
    .markEmpty  (markEmpty),
    .pendingLast(pendingLast),
    .visitIdx   (visitIdx),
    .flagOut    (flagOut),
    .ch0Hit     (ch0Hit),
    .chTopHit   (chTopHit)
  );

  assign addrOut  = addrOe ? visitIdx : '0;
  assign nbrLoOut = ch0Hit;
  assign nbrHiOut = chTopHit;
  assign nbrLoOe  = neighEn & acqMode & ch0Hit;
  assign nbrHiOe  = neighEn & acqMode & chTopHit;

  // R7: boundary lines are driven only in acquisition with neighbors on
  a_r7_boundary_drive: assert property (@(posedge clk) disable iff (!rstN)
    (nbrLoOe || nbrHiOe) |-> (acqEnable && !cfgEnable && neighEn));

  // R4: address bus stays quiet while the chip lacks the token
  a_r4_addr_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !addrOe |-> (addrOut == '0));

endmodule

// File: tb/sparse_token_readout_bench.sv
module sparse_token_readout_bench;

  localparam int N  = 16;
  localparam int AW = 4;
  localparam int LA = 3;
  localparam int LB = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          acqEnable = 1'b0;
  logic          cfgEnable = 1'b0;
  logic [N-1:0]  peakHit = '0;
  logic [N-1:0]  chanMask = '0;
  logic          neighEn = 1'b0;
  logic          bridgeEn = 1'b0;
  logic          nbrLoIn = 1'b0;
  logic          nbrHiIn = 1'b0;
  logic          tokIn = 1'b0;
  logic          nbrLoOut, nbrLoOe, nbrHiOut, nbrHiOe;
  logic          tokOut, addrOe, flagOut;
  logic [AW-1:0] addrOut;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  sparse_token_readout #(
    .NUM_CH(N), .ADDR_W(AW), .LINK_A(LA), .LINK_B(LB)
  ) u_sparse_token_readout (
    .clk(clk), .rstN(rstN), .acqEnable(acqEnable), .cfgEnable(cfgEnable),
    .peakHit(peakHit), .chanMask(chanMask), .neighEn(neighEn),
    .bridgeEn(bridgeEn), .nbrLoIn(nbrLoIn), .nbrLoOut(nbrLoOut),
    .nbrLoOe(nbrLoOe), .nbrHiIn(nbrHiIn), .nbrHiOut(nbrHiOut),
    .nbrHiOe(nbrHiOe), .tokIn(tokIn), .tokOut(tokOut), .addrOut(addrOut),
    .addrOe(addrOe), .flagOut(flagOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] expMarks(input logic [N-1:0] hits,
      input logic [N-1:0] mask, input bit nEn, input bit bEn,
      input bit lo, input bit hi);
    logic [N-1:0] h;
    logic [N-1:0] r;
    h = hits & ~mask;
    r = '0;
    for (int c = 0; c < N; c++) begin
      bit m;
      m = h[c];
      if (nEn) begin
        if (c > 0 && h[c-1]) m = 1'b1;
        if (c < N-1 && h[c+1]) m = 1'b1;
        if (c == 0 && lo) m = 1'b1;
        if (c == N-1 && hi) m = 1'b1;
        if (bEn && c == LA && h[LB]) m = 1'b1;
        if (bEn && c == LB && h[LA]) m = 1'b1;
      end
      r[c] = m & ~mask[c];
    end
    return r;
  endfunction

  task automatic runCase(input logic [N-1:0] hits, input logic [N-1:0] mask,
      input bit nEn, input bit bEn, input bit lo, input bit hi);
    logic [N-1:0] exp;
    logic [N-1:0] h;
    exp = expMarks(hits, mask, nEn, bEn, lo, hi);
    h = hits & ~mask;
    // clear
    @(negedge clk);
    cfgEnable = 1'b1; acqEnable = 1'b0;
    chanMask = mask; neighEn = nEn; bridgeEn = bEn;
    @(negedge clk);
    cfgEnable = 1'b0;
    chk(flagOut == 1'b0, "R2 flag cleared", flagOut, 0);
    // acquisition
    acqEnable = 1'b1;
    peakHit = hits; nbrLoIn = lo; nbrHiIn = hi;
    @(negedge clk);
    peakHit = '0; nbrLoIn = 1'b0; nbrHiIn = 1'b0;
    chk(flagOut == (|h), "R3/R9 flag after first peak", flagOut, int'(|h));
    chk(nbrLoOe == (nEn & h[0]), "R7 low boundary enable", nbrLoOe, int'(nEn & h[0]));
    chk(nbrHiOe == (nEn & h[N-1]), "R7 high boundary enable", nbrHiOe, int'(nEn & h[N-1]));
    if (nbrLoOe) chk(nbrLoOut == 1'b1, "R7 low boundary value", nbrLoOut, 1);
    // readout mode, stray peaks must be ignored
    acqEnable = 1'b0;
    peakHit = ~hits;
    @(negedge clk);
    peakHit = '0;
    chk(flagOut == (|h), "R1 flag unchanged by readout peaks", flagOut, int'(|h));
    chk(nbrLoOe == 1'b0, "R7 no drive outside acquisition", nbrLoOe, 0);
    chk(addrOe == 1'b0 && addrOut == '0, "R4 bus quiet before token", addrOut, 0);
    tokIn = 1'b1;
    @(posedge clk); #1;
    for (int c = 0; c < N; c++) begin
      if (exp[c]) begin
        chk(addrOe == 1'b1 && int'(addrOut) == c,
            "R4/R6/R8/R9 visit order", addrOe ? int'(addrOut) : -1, c);
        chk(tokOut == 1'b0, "R5 token held during visit", tokOut, 0);
        @(posedge clk); #1;
      end
    end
    chk(addrOe == 1'b0 && addrOut == '0, "R4 bus released", addrOe, 0);
    chk(tokOut == 1'b1, "R5 token out rises", tokOut, 1);
    #4;
    chk(tokOut == 1'b1, "R5 token out half period", tokOut, 1);
    #4;
    chk(tokOut == 1'b1, "R5 token out one period", tokOut, 1);
    #4;
    chk(tokOut == 1'b0, "R5 token out ends at 1.5 periods", tokOut, 0);
    #4;
    chk(tokOut == 1'b0 && addrOe == 1'b0, "R5 no second pass", tokOut, 0);
    @(negedge clk);
    tokIn = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(flagOut == 1'b0 && addrOe == 1'b0 && tokOut == 1'b0, "R2 reset state", flagOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(nbrLoOe == 1'b0 && nbrHiOe == 1'b0, "R7 reset boundary", nbrLoOe, 0);

    // Empty chip: token passes at once (R5)
    runCase('0, '0, 1'b1, 1'b1, 1'b0, 1'b0);
    // All hits masked: nothing marked (R9)
    runCase('1, '1, 1'b1, 1'b1, 1'b1, 1'b1);
    // Boundary requests only (R7)
    runCase('0, '0, 1'b1, 1'b0, 1'b1, 1'b1);
    runCase('0, '0, 1'b0, 1'b0, 1'b1, 1'b1);

    // Single-hit sweep, neighbors off and on (R1, R4, R6, R8)
    for (int nE = 0; nE < 2; nE++) begin
      for (int c = 0; c < N; c++) begin
        runCase(N'(1) << c, '0, nE[0], 1'b1, 1'b0, 1'b0);
      end
    end

    // Pair sweep with rotating mask, bridge and boundary lines (R6-R9)
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        runCase((N'(1) << i) | (N'(1) << j), N'(1) << ((i * 5 + j) % N),
                1'b1, ((i + j) % 2) == 1, i[0], j[0]);
      end
    end

    // Dense pattern, no neighbors (R4)
    runCase(16'hA5C3, 16'h0100, 1'b0, 1'b0, 1'b0, 1'b0);
    runCase(16'hFFFF, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule